// File: doc/BRIEF.md
# Receive Frame Status Queue with Overrun Lock

This block sits behind a framed serial receiver that cannot be stalled. Each received byte arrives with a valid strobe. The byte that closes a frame carries an end marker together with that frame's CRC-error and abort indications. Accepted bytes go into a receive data FIFO, which is drained through a valid/ready output stream. The block counts the bytes of the frame in progress. When the frame closes, it pushes one entry into an eight-deep status queue, holding the frame length and the error flags of that frame.

Software reads a status entry through a small read port, selected by `reg_sel`. Two selects return the low and high parts of the length. A third select returns the error byte, and reading it removes the entry. A fourth select is the resume access. A byte that arrives while the data FIFO is full is an overrun. An overrun raises an interrupt, throws away the rest of that frame and locks reception. The lock is released only by a FIFO reset followed later by a resume read.

The input has no ready signal, because a line receiver cannot wait. Back-pressure on the output stream is the only flow control. While `dout_ready` is low, the data FIFO fills, and a byte that finds it full causes an overrun. On the output, `dout_data` holds steady while `dout_valid` is high and `dout_ready` is low.

Top module: `rxs_frame_status`

## Requirements
- R1: Bytes that are stored leave on `dout_data` in arrival order. While `dout_valid` is high and `dout_ready` is low, `dout_valid` and `dout_data` hold steady.
- R2: When a byte with `in_last` is stored, the status queue takes an entry whose length is the frame's byte count. Select 0 reads length bits [7:0] and select 1 reads length bits [11:8] in bits [3:0], with the other bits 0. Reading either length select does not remove the entry.
- R3: Select 2 reads the error byte of the oldest entry: bit 0 CRC error, bit 1 abort, bit 2 frame too long, bit 7 entry valid. A read on select 2 removes the entry.
- R4: The status queue holds eight entries and returns them in order. When it is empty, all three status selects read 0, so bit 7 of select 2 reads 0.
- R5: A frame that closes while eight entries are waiting is dropped, and the sticky output `sts_ovf` is set. A read on select 3 clears `sts_ovf`.
- R6: A byte that arrives while the data FIFO holds 16 bytes is not stored. From the next cycle on, `irq_ovr` is high.
- R7: While `irq_ovr` is high, incoming bytes and end markers store no data and add no status entry.
- R8: A select 3 read with no `fifo_reset` since the overrun leaves `irq_ovr` high. A `fifo_reset` empties the data FIFO. A later select 3 read drops `irq_ovr` one cycle after the read.
- R9: After an overrun, the bytes that follow are discarded until that frame's end marker, even when the lock was released in between. The next frame is received in full.
- R10: A frame longer than 4095 bytes reports length 4095 with bit 2 set. A frame of exactly 4095 bytes reports 4095 with bit 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte closes the frame |
| in_crc_err | input | 1 | CRC error of the closing frame, sampled with `in_last` |
| in_abort | input | 1 | Abort of the closing frame, sampled with `in_last` |
| dout_valid | output | 1 | Data FIFO not empty |
| dout_ready | input | 1 | Consumer takes the byte |
| dout_data | output | 8 | Oldest stored byte |
| reg_rd | input | 1 | Read strobe for the selected register |
| reg_sel | input | 2 | 0 length low, 1 length high, 2 error byte (removes the entry), 3 resume |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| fifo_reset | input | 1 | Empties the receive data FIFO |
| irq_ovr | output | 1 | Overrun interrupt, held until the lock is released |
| sts_ovf | output | 1 | Sticky flag: a status entry was dropped |

## Verification
The frame path is driven with short clean frames, a frame carrying a CRC error, an aborted 300-byte frame, a frame of exactly 4095 bytes and one of 4097 bytes. These separate the low and high length fields, show each error bit is placed on its own, and locate the saturation point. A run of nine one-byte-apart frames against an idle reader tells in-order delivery apart from the drop of the ninth entry. Overrun is forced by holding `dout_ready` low. The lock is then released once with the frame's end already seen, and once while the frame's tail is still arriving. Comparing the two shows that tail discard is independent of the lock, and that a resume read without a FIFO reset does nothing.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    SEL_LEN_LO = 2'd0,
    SEL_LEN_HI = 2'd1,
    SEL_ERR    = 2'd2,
    SEL_RESUME = 2'd3
  } rxs_sel_e;

  localparam int ERRB_CRC   = 0;
  localparam int ERRB_ABORT = 1;
  localparam int ERRB_LONG  = 2;
  localparam int ERRB_VALID = 7;
endpackage

// File: rtl/rxs_sync_fifo.sv
module rxs_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic          wr_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          rd_en;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rd_en = pop && !empty;
  assign wr_ok = push && (!full || rd_en);
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= nxt(wp);
      if (rd_en) rp <= nxt(rp);
      if (wr_ok && !rd_en) cnt <= cnt + 1'b1;
      else if (rd_en && !wr_ok) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clr) mem[wp] <= wdata;
  end
endmodule

// File: rtl/rxs_len_track.sv
module rxs_len_track #(
  parameter int LEN_W = 12,
  localparam logic [LEN_W-1:0] LMAX = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             last,
  output logic [LEN_W-1:0] fr_len,
  output logic             fr_long
);
  logic [LEN_W-1:0] cnt;
  logic             long_q;
  logic             at_max;

  assign at_max  = (cnt == LMAX);
  assign fr_len  = at_max ? LMAX : cnt + 1'b1;
  assign fr_long = long_q || at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      long_q <= 1'b0;
    end else if (clear || (take && last)) begin
      cnt    <= '0;
      long_q <= 1'b0;
    end else if (take) begin
      if (at_max) long_q <= 1'b1;
      else        cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxs_ovr_lock.sv
module rxs_ovr_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic fifo_rst,
  input  logic resume_rd,
  output logic locked
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      armed  <= 1'b0;
    end else if (ovr_evt) begin
      locked <= 1'b1;
      armed  <= 1'b0;
    end else if (locked && fifo_rst) begin
      armed  <= 1'b1;
    end else if (locked && armed && resume_rd) begin
      locked <= 1'b0;
      armed  <= 1'b0;
    end
  end
endmodule

// File: rtl/rxs_frame_status.sv
module rxs_frame_status
  import rxs_pkg::*;
#(
  parameter int DQ_DEPTH = 16,
  parameter int SQ_DEPTH = 8,
  parameter int LEN_W    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_crc_err,
  input  logic       in_abort,
  output logic       dout_valid,
  input  logic       dout_ready,
  output logic [7:0] dout_data,
  input  logic       reg_rd,
  input  logic [1:0] reg_sel,
  output logic [7:0] reg_rdata,
  input  logic       fifo_reset,
  output logic       irq_ovr,
  output logic       sts_ovf
);
  localparam int SW = LEN_W + 3;

  logic          locked, drop_tail;
  logic          accept, ovr_evt, dq_push, dq_full, dq_empty, dq_wr_ok;
  logic          st_push, st_pop, st_full, st_empty, st_wr_ok, resume_rd;
  logic [LEN_W-1:0] fr_len;
  logic          fr_long;
  logic [SW-1:0] st_wdata, st_rdata;
  logic [15:0]   len_ext;

  assign accept    = in_valid && !locked && !drop_tail;
  assign ovr_evt   = accept && dq_full;
  assign dq_push   = accept && !dq_full && !fifo_reset;
  assign st_push   = dq_push && in_last;
  assign resume_rd = reg_rd && (reg_sel == SEL_RESUME);
  assign st_pop    = reg_rd && (reg_sel == SEL_ERR) && !st_empty;
  assign dout_valid = !dq_empty;
  assign irq_ovr    = locked;

  rxs_sync_fifo #(.W(8), .DEPTH(DQ_DEPTH)) u_dq (
    .clk, .rst_n, .clr(fifo_reset), .push(dq_push), .wdata(in_data),
    .pop(dout_valid && dout_ready), .rdata(dout_data),
    .full(dq_full), .empty(dq_empty), .wr_ok(dq_wr_ok)
  );

  rxs_len_track #(.LEN_W(LEN_W)) u_len (
    .clk, .rst_n, .clear(ovr_evt), .take(dq_push), .last(in_last),
    .fr_len, .fr_long
  );

  assign st_wdata = {fr_long, in_abort, in_crc_err, fr_len};

  rxs_sync_fifo #(.W(SW), .DEPTH(SQ_DEPTH)) u_sq (
    .clk, .rst_n, .clr(1'b0), .push(st_push), .wdata(st_wdata),
    .pop(st_pop), .rdata(st_rdata),
    .full(st_full), .empty(st_empty), .wr_ok(st_wr_ok)
  );

  rxs_ovr_lock u_lock (
    .clk, .rst_n, .ovr_evt, .fifo_rst(fifo_reset), .resume_rd, .locked
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_tail <= 1'b0;
      sts_ovf   <= 1'b0;
    end else begin
      if (ovr_evt && !in_last)                drop_tail <= 1'b1;
      else if (drop_tail && in_valid && in_last) drop_tail <= 1'b0;
      if (st_push && !st_wr_ok) sts_ovf <= 1'b1;
      else if (resume_rd)       sts_ovf <= 1'b0;
    end
  end

  assign len_ext = 16'(st_rdata[LEN_W-1:0]);

  always_comb begin
    reg_rdata = '0;
    if (!st_empty) begin
      unique case (reg_sel)
        SEL_LEN_LO: reg_rdata = len_ext[7:0];
        SEL_LEN_HI: reg_rdata = len_ext[15:8];
        SEL_ERR: begin
          reg_rdata[ERRB_CRC]   = st_rdata[LEN_W];
          reg_rdata[ERRB_ABORT] = st_rdata[LEN_W+1];
          reg_rdata[ERRB_LONG]  = st_rdata[LEN_W+2];
          reg_rdata[ERRB_VALID] = 1'b1;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = dq_wr_ok;
endmodule

// File: rtl/rxs_frame_status_chk.sv
module rxs_frame_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       reg_rd,
  input logic [1:0] reg_sel,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       fifo_reset,
  input logic       irq_ovr,
  input logic       sts_ovf,
  input logic       dq_full,
  input logic       dq_push,
  input logic       drop_tail
);
  // R1: output held under back-pressure
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && !fifo_reset) |=> (dout_valid && $stable(dout_data)));

  // R6: byte into full FIFO raises the interrupt
  a_r6_ovr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dq_full && !irq_ovr && !drop_tail) |=> irq_ovr);

  // R7: nothing stored while locked
  a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> !dq_push);

  // R8: interrupt held until a resume read
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovr && !(reg_rd && reg_sel == 2'd3)) |=> irq_ovr);

  // R8: FIFO reset empties the data FIFO
  a_r8_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> !dout_valid);

  // R5: drop flag is sticky until a resume read
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ovf && !(reg_rd && reg_sel == 2'd3)) |=> sts_ovf);
endmodule

bind rxs_frame_status rxs_frame_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_rd(reg_rd),
  .reg_sel(reg_sel), .dout_valid(dout_valid), .dout_ready(dout_ready),
  .dout_data(dout_data), .fifo_reset(fifo_reset), .irq_ovr(irq_ovr),
  .sts_ovf(sts_ovf), .dq_full(dq_full), .dq_push(dq_push),
  .drop_tail(drop_tail)
);

// File: tb/sim_rxs_frame_status.sv
module sim_rxs_frame_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, in_crc_err = 0, in_abort = 0;
  logic [7:0] in_data = 0;
  logic dout_valid, dout_ready = 0;
  logic [7:0] dout_data;
  logic reg_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_rdata;
  logic fifo_reset = 0, irq_ovr, sts_ovf;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  byte unsigned got[$];

  always #4 clk = ~clk;

  rxs_frame_status u0 (.*);

  always @(posedge clk) if (dout_valid && dout_ready) got.push_back(dout_data);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic l, input logic c, input logic a);
    in_valid = 1; in_data = d; in_last = l; in_crc_err = c; in_abort = a;
    @(negedge clk);
    in_valid = 0; in_last = 0; in_crc_err = 0; in_abort = 0;
  endtask

  task automatic frame(input int n, input int base, input logic c, input logic a);
    for (int i = 0; i < n; i++) put(8'(base + i), i == n - 1, c, a);
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    reg_sel = s; #1; v = reg_rdata; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    chk("R1 reset dout_valid", dout_valid, 0);
    chk("R8 reset irq", irq_ovr, 0);
    chk("R5 reset sts_ovf", sts_ovf, 0);
    rd(2, v); chk("R4 empty err byte", v, 0);
  endtask

  task automatic t_basic;
    int v;
    got.delete(); dout_ready = 1;
    frame(3, 8'h10, 0, 0);
    frame(5, 8'h40, 1, 0);
    idle(3);
    chk("R1 byte count", got.size(), 8);
    for (int i = 0; i < 8; i++)
      chk("R1 order", (i < got.size()) ? got[i] : -1, (i < 3) ? 8'h10 + i : 8'h40 + i - 3);
    rd(0, v); chk("R2 len lo f1", v, 3);
    rd(0, v); chk("R2 len lo reread no pop", v, 3);
    rd(1, v); chk("R2 len hi f1", v, 0);
    rd(2, v); chk("R3 err f1", v, 8'h80);
    rd(0, v); chk("R2 len lo f2", v, 5);
    rd(2, v); chk("R3 err f2 crc", v, 8'h81);
    rd(2, v); chk("R4 empty after pops", v, 0);
  endtask

  task automatic t_lengths;
    int v;
    got.delete(); dout_ready = 1;
    frame(300, 0, 0, 1);
    frame(4095, 0, 0, 0);
    frame(4097, 0, 0, 0);
    idle(3);
    chk("R1 long drain count", got.size(), 300 + 4095 + 4097);
    rd(0, v); chk("R2 len lo 300", v, 44);
    rd(1, v); chk("R2 len hi 300", v, 1);
    rd(2, v); chk("R3 abort bit", v, 8'h82);
    rd(0, v); chk("R10 len lo 4095", v, 8'hFF);
    rd(1, v); chk("R10 len hi 4095", v, 8'h0F);
    rd(2, v); chk("R10 4095 not long", v, 8'h80);
    rd(0, v); chk("R10 len lo sat", v, 8'hFF);
    rd(1, v); chk("R10 len hi sat", v, 8'h0F);
    rd(2, v); chk("R10 long bit", v, 8'h84);
  endtask

  task automatic t_status_full;
    int v;
    dout_ready = 1;
    for (int k = 1; k <= 9; k++) begin frame(k, 0, 0, 0); idle(1); end
    chk("R5 sts_ovf set", sts_ovf, 1);
    for (int k = 1; k <= 8; k++) begin
      rd(0, v); chk("R4 order len", v, k);
      rd(2, v); chk("R4 valid", v, 8'h80);
    end
    rd(2, v); chk("R5 ninth dropped", v, 0);
    rd(3, v); chk("R5 sts_ovf cleared", sts_ovf, 0);
    chk("R8 resume when unlocked", irq_ovr, 0);
  endtask

  task automatic t_overrun;
    int v;
    got.delete(); dout_ready = 0;
    frame(20, 0, 0, 0);
    chk("R6 irq raised", irq_ovr, 1);
    dout_ready = 1; idle(20);
    chk("R6 only 16 stored", got.size(), 16);
    chk("R6 last stored byte", (got.size() > 0) ? got[got.size() - 1] : -1, 15);
    got.delete();
    frame(2, 8'hA0, 0, 0); idle(2);
    chk("R7 no data while locked", got.size(), 0);
    rd(2, v); chk("R7 no status while locked", v, 0);
    rd(3, v); chk("R8 resume without reset", irq_ovr, 1);
    fifo_reset = 1; @(negedge clk); fifo_reset = 0;
    chk("R8 fifo empty after reset", dout_valid, 0);
    chk("R8 still locked after reset", irq_ovr, 1);
    rd(3, v); chk("R8 released", irq_ovr, 0);
    frame(3, 8'hC0, 0, 0); idle(3);
    chk("R8 rx after recovery", got.size(), 3);
    rd(0, v); chk("R8 len after recovery", v, 3);
    rd(2, v);
  endtask

  task automatic t_tail;
    int v;
    got.delete(); dout_ready = 0;
    for (int i = 0; i < 17; i++) put(8'(i), 0, 0, 0);
    chk("R6 irq mid frame", irq_ovr, 1);
    fifo_reset = 1; @(negedge clk); fifo_reset = 0;
    rd(3, v); chk("R9 released mid frame", irq_ovr, 0);
    dout_ready = 1;
    frame(3, 8'h70, 0, 0); idle(2);
    chk("R9 tail discarded", got.size(), 0);
    rd(2, v); chk("R9 no tail status", v, 0);
    frame(2, 8'h90, 0, 0); idle(2);
    chk("R9 next frame data", got.size(), 2);
    rd(0, v); chk("R9 next frame len", v, 2);
    rd(2, v); chk("R9 next frame err", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_status_full();
    t_overrun();
    t_tail();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule